// File: doc/BRIEF.md
# Multi-Sector Disk Read Sequencer

This block is a hardwired state machine that runs one disk read command from start to finish. The host starts it with a pointer to a four-word parameter block in host memory and a drive number. The sequencer selects the drive and tests that it is ready. It then reads the parameter block over a single-channel DMA port: the sector header, the first memory address, the number of sectors and a password. If the password does not match a built-in constant, no disk access takes place.

For each sector, the sequencer waits for the sector pulse of the wanted sector and then for a start-of-data sync strobe. It checks the header word that follows, stores the sector's data words one by one at rising memory addresses, and finally takes the result of an external CRC comparison. After each good sector it counts down the sector total and moves to the next sector number. It stops with a done flag when the total is used up.

Every failure ends the command at once with its own sticky status flag. Both normal completion and an abort raise a level interrupt.

Top module: `diskReadSeq`

## Requirements
- R1: One cycle after a start pulse the sequencer samples `driveReady`; if it is low, status bit 2 (not ready) is set, the command ends and no DMA request is made. While idle, `dmaReq` stays low.
- R2: The parameter block is fetched with four DMA reads (`dmaWrite`=0) at `cmdPtr`, `cmdPtr`+1, `cmdPtr`+2, `cmdPtr`+3. In that order the words are: the header ({track[15:8], sector[7:0]}), the first memory address, the sector count and the password.
- R3: A password that differs from the `PASSWORD` parameter sets status bit 4 (program error) and ends the command before any disk event is accepted. No memory write follows.
- R4: While waiting for a sector, only a `sectorPulse` whose `sectorNum` equals the header's low byte moves the sequencer on. A pulse for any other sector is ignored. The second `indexPulse` seen without a match sets status bit 5 (address error) and ends the command.
- R5: After `syncFound`, the first `wordValid` word is compared with the whole 16-bit header. A mismatch sets status bit 5 and ends the command.
- R6: Each sector's `WORDS_PER_SECTOR` data words are written by DMA (`dmaWrite`=1) in arrival order to consecutive addresses. The first word goes to the starting address, and the address carries on across sectors.
- R7: A `crcStrobe` with `crcMatch` low sets status bit 6 (data error) and ends the command.
- R8: After a good sector with more than one sector left, the sector count drops by one and the header's low byte rises by one, wrapping at 8 bits. The next sector is matched and compared against this new header. When the count is 1 or 0, status bit 0 (done) is set, so a count of 0 reads one sector. Every command ends with exactly one of bits 0, 2, 4, 5, 6, 7 set.
- R9: If a data word arrives while the previous word's DMA write has not been acknowledged (no `dmaAck` in that cycle or earlier), status bit 7 (overrun) is set. The command then ends and the pending write is dropped.
- R10: `irq` is a level that goes high when a command ends and stays high until `statusRead` or an accepted `cmdStart`.
- R11: Status flags are sticky. A `statusRead` pulse, or a `cmdStart` accepted while idle, clears all flags and `irq` at the next edge. A flag set in the same cycle wins over the clear.
- R12: A `faultIn` pulse sets status bit 1 and leaves `irq` alone. A `seekDoneIn` pulse sets status bit 3 and raises `irq`. Both work whether the sequencer is busy or idle.
- R13: A `cmdStart` while `busy` is high is ignored. The running command's parameters and result do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdStart | input | 1 | Start pulse for a read command |
| cmdPtr | input | DATA_W | Host address of the parameter block |
| cmdDrive | input | DRIVE_W | Drive number for the command |
| statusRead | input | 1 | Host status read; clears flags and irq |
| driveSel | output | DRIVE_W | Selected drive, latched at start |
| driveReady | input | 1 | Ready line of the selected drive |
| faultIn | input | 1 | Drive fault event pulse |
| seekDoneIn | input | 1 | Seek-finished event pulse |
| indexPulse | input | 1 | Once-per-revolution index pulse |
| sectorPulse | input | 1 | Sector mark pulse |
| sectorNum | input | SEC_W | Number of the sector under the head, valid with sectorPulse |
| syncFound | input | 1 | Start-of-data sync detected |
| wordValid | input | 1 | Assembled word strobe |
| wordData | input | DATA_W | Assembled word from the disk |
| crcStrobe | input | 1 | CRC comparison result valid |
| crcMatch | input | 1 | CRC comparison result |
| dmaReq | output | 1 | DMA request, held until dmaAck |
| dmaWrite | output | 1 | 1 = write to host memory, 0 = read |
| dmaAddr | output | DATA_W | DMA word address |
| dmaWData | output | DATA_W | DMA write data |
| dmaAck | input | 1 | DMA acknowledge, one cycle |
| dmaRData | input | DATA_W | DMA read data, valid with dmaAck |
| status | output | 8 | Sticky status flags |
| irq | output | 1 | Interrupt level |
| busy | output | 1 | A command is running |

## Verification
Good reads are tried with random parameter pointers, start addresses, sector numbers, tracks, data and DMA latencies. Sector counts of 0, 1 and 2 are used, which separates the single-sector end from the step to the next header. A mismatching sector pulse is sent before the wanted one, and a second start is issued mid-command; these show that wrong sectors and busy starts leave the result untouched. Directed runs trigger each abort cause on its own: not ready, bad password, index timeout, header mismatch, CRC error and a stalled DMA overrun. In each case the single flag, the irq level and the count of DMA reads and writes together show where the command stopped.

// File: rtl/drseq_pkg.sv
package drseq_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_READY, S_FETCH, S_CHKPW, S_SECWAIT,
    S_SYNC, S_HDR, S_DATA, S_CRC, S_DRAIN
  } seqState_t;

  localparam int FLAG_N  = 8;
  localparam int F_DONE  = 0;
  localparam int F_FAULT = 1;
  localparam int F_NRDY  = 2;
  localparam int F_SEEK  = 3;
  localparam int F_PROG  = 4;
  localparam int F_ADDR  = 5;
  localparam int F_DATA  = 6;
  localparam int F_OVR   = 7;
  localparam logic [FLAG_N-1:0] OUTCOME_MASK = 8'hF5;

  // strobes from control to datapath
  typedef struct packed {
    logic              start;
    logic              fetch;
    logic              secWait;
    logic              clrIdx;
    logic              loadWords;
    logic              dataEn;
    logic              nextSector;
    logic              dropPending;
    logic              finish;
    logic [FLAG_N-1:0] setFlags;
  } seqCtl_t;

  // raw conditions from datapath to control
  typedef struct packed {
    logic paramLast;
    logic pwOk;
    logic secHit;
    logic hdrOk;
    logic timeout;
    logic lastWord;
    logic overrun;
    logic pending;
    logic lastSector;
  } seqStat_t;

endpackage

// File: rtl/drseqControl.sv
module drseqControl
  import drseq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cmdStart,
  input  logic     driveReady,
  input  logic     syncFound,
  input  logic     wordValid,
  input  logic     crcStrobe,
  input  logic     crcMatch,
  input  seqStat_t stat,
  output seqCtl_t  ctl,
  output logic     busy
);

  seqState_t state, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  assign busy = (state != S_IDLE);

  always_comb begin
    nxt = state;
    ctl = '0;
    unique case (state)
      S_IDLE: if (cmdStart) begin
        ctl.start = 1'b1;
        nxt = S_READY;
      end
      S_READY: if (driveReady) nxt = S_FETCH;
      else begin
        ctl.setFlags[F_NRDY] = 1'b1;
        ctl.finish = 1'b1;
        nxt = S_IDLE;
      end
      S_FETCH: begin
        ctl.fetch = 1'b1;
        if (stat.paramLast) nxt = S_CHKPW;
      end
      S_CHKPW: if (stat.pwOk) begin
        ctl.clrIdx = 1'b1;
        nxt = S_SECWAIT;
      end else begin
        ctl.setFlags[F_PROG] = 1'b1;
        ctl.finish = 1'b1;
        nxt = S_IDLE;
      end
      S_SECWAIT: begin
        ctl.secWait = 1'b1;
        if (stat.secHit) nxt = S_SYNC;
        else if (stat.timeout) begin
          ctl.setFlags[F_ADDR] = 1'b1;
          ctl.finish = 1'b1;
          nxt = S_IDLE;
        end
      end
      S_SYNC: if (syncFound) nxt = S_HDR;
      S_HDR: if (wordValid) begin
        if (stat.hdrOk) begin
          ctl.loadWords = 1'b1;
          nxt = S_DATA;
        end else begin
          ctl.setFlags[F_ADDR] = 1'b1;
          ctl.finish = 1'b1;
          nxt = S_IDLE;
        end
      end
      S_DATA: begin
        ctl.dataEn = 1'b1;
        if (stat.overrun) begin
          ctl.setFlags[F_OVR] = 1'b1;
          ctl.finish = 1'b1;
          ctl.dropPending = 1'b1;
          nxt = S_IDLE;
        end else if (stat.lastWord) nxt = S_CRC;
      end
      S_CRC: if (crcStrobe) begin
        if (crcMatch) nxt = S_DRAIN;
        else begin
          ctl.setFlags[F_DATA] = 1'b1;
          ctl.finish = 1'b1;
          ctl.dropPending = 1'b1;
          nxt = S_IDLE;
        end
      end
      S_DRAIN: if (!stat.pending) begin
        if (stat.lastSector) begin
          ctl.setFlags[F_DONE] = 1'b1;
          ctl.finish = 1'b1;
          nxt = S_IDLE;
        end else begin
          ctl.nextSector = 1'b1;
          ctl.clrIdx = 1'b1;
          nxt = S_SECWAIT;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

endmodule

// File: rtl/drseqDatapath.sv
module drseqDatapath
  import drseq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int WORDS_PER_SECTOR = 128,
  parameter int SEC_W = 8,
  parameter int DRIVE_W = 2,
  parameter logic [DATA_W-1:0] PASSWORD = 'hC35A
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqCtl_t             ctl,
  output seqStat_t            stat,
  input  logic [DATA_W-1:0]   cmdPtr,
  input  logic [DRIVE_W-1:0]  cmdDrive,
  output logic [DRIVE_W-1:0]  driveSel,
  input  logic                statusRead,
  input  logic                faultIn,
  input  logic                seekDoneIn,
  input  logic                indexPulse,
  input  logic                sectorPulse,
  input  logic [SEC_W-1:0]    sectorNum,
  input  logic                wordValid,
  input  logic [DATA_W-1:0]   wordData,
  output logic                dmaReq,
  output logic                dmaWrite,
  output logic [DATA_W-1:0]   dmaAddr,
  output logic [DATA_W-1:0]   dmaWData,
  input  logic                dmaAck,
  input  logic [DATA_W-1:0]   dmaRData,
  output logic [FLAG_N-1:0]   status,
  output logic                irq
);

  localparam int CNT_W = $clog2(WORDS_PER_SECTOR + 1);
  localparam int PARAM_N = 4;
  localparam int IDX_W = $clog2(PARAM_N);

  logic [DATA_W-1:0] ptrR, hdrR, memAddr, blockLen, pwR, wbuf;
  logic [IDX_W-1:0]  fetchIdx;
  logic [CNT_W-1:0]  wordCnt;
  logic              idxSeen, pending;
  logic              accept, writeDone, overrunRaw;
  logic [FLAG_N-1:0] eventFlags;

  assign writeDone  = pending && dmaAck;
  assign overrunRaw = wordValid && pending && !dmaAck;
  assign accept     = ctl.dataEn && wordValid && !overrunRaw;

  assign stat.paramLast  = dmaAck && (fetchIdx == IDX_W'(PARAM_N - 1));
  assign stat.pwOk       = (pwR == PASSWORD);
  assign stat.secHit     = sectorPulse && (sectorNum == hdrR[SEC_W-1:0]);
  assign stat.timeout    = indexPulse && idxSeen;
  assign stat.hdrOk      = (wordData == hdrR);
  assign stat.overrun    = overrunRaw;
  assign stat.lastWord   = wordValid && !overrunRaw && (wordCnt == CNT_W'(1));
  assign stat.pending    = pending;
  assign stat.lastSector = (blockLen <= DATA_W'(1));

  assign dmaReq   = ctl.fetch || pending;
  assign dmaWrite = pending;
  assign dmaAddr  = pending ? memAddr : (ptrR + DATA_W'(fetchIdx));
  assign dmaWData = wbuf;

  always_comb begin
    eventFlags = ctl.setFlags;
    eventFlags[F_FAULT] = eventFlags[F_FAULT] | faultIn;
    eventFlags[F_SEEK]  = eventFlags[F_SEEK] | seekDoneIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrR <= '0; hdrR <= '0; memAddr <= '0; blockLen <= '0; pwR <= '0;
      wbuf <= '0; fetchIdx <= '0; wordCnt <= '0; idxSeen <= 1'b0;
      pending <= 1'b0; driveSel <= '0; status <= '0; irq <= 1'b0;
    end else begin
      if (ctl.start) begin
        ptrR     <= cmdPtr;
        driveSel <= cmdDrive;
        fetchIdx <= '0;
      end
      if (ctl.fetch && dmaAck) begin
        fetchIdx <= fetchIdx + 1'b1;
        case (fetchIdx)
          IDX_W'(0): hdrR     <= dmaRData;
          IDX_W'(1): memAddr  <= dmaRData;
          IDX_W'(2): blockLen <= dmaRData;
          default:   pwR      <= dmaRData;
        endcase
      end
      if (ctl.clrIdx) idxSeen <= 1'b0;
      else if (ctl.secWait && indexPulse) idxSeen <= 1'b1;
      if (ctl.loadWords) wordCnt <= CNT_W'(WORDS_PER_SECTOR);
      if (writeDone) memAddr <= memAddr + 1'b1;
      if (ctl.dropPending) pending <= 1'b0;
      else if (accept) begin
        pending <= 1'b1;
        wbuf    <= wordData;
        wordCnt <= wordCnt - 1'b1;
      end else if (writeDone) pending <= 1'b0;
      if (ctl.nextSector) begin
        blockLen <= blockLen - 1'b1;
        hdrR[SEC_W-1:0] <= hdrR[SEC_W-1:0] + 1'b1;
      end
      status <= ((ctl.start || statusRead) ? '0 : status) | eventFlags;
      irq    <= ((ctl.start || statusRead) ? 1'b0 : irq) | ctl.finish | seekDoneIn;
    end
  end

endmodule

// File: rtl/diskReadSeq.sv
module diskReadSeq
  import drseq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int WORDS_PER_SECTOR = 128,
  parameter int SEC_W = 8,
  parameter int DRIVE_W = 2,
  parameter logic [DATA_W-1:0] PASSWORD = 'hC35A
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdStart,
  input  logic [DATA_W-1:0]  cmdPtr,
  input  logic [DRIVE_W-1:0] cmdDrive,
  input  logic               statusRead,
  output logic [DRIVE_W-1:0] driveSel,
  input  logic               driveReady,
  input  logic               faultIn,
  input  logic               seekDoneIn,
  input  logic               indexPulse,
  input  logic               sectorPulse,
  input  logic [SEC_W-1:0]   sectorNum,
  input  logic               syncFound,
  input  logic               wordValid,
  input  logic [DATA_W-1:0]  wordData,
  input  logic               crcStrobe,
  input  logic               crcMatch,
  output logic               dmaReq,
  output logic               dmaWrite,
  output logic [DATA_W-1:0]  dmaAddr,
  output logic [DATA_W-1:0]  dmaWData,
  input  logic               dmaAck,
  input  logic [DATA_W-1:0]  dmaRData,
  output logic [7:0]         status,
  output logic               irq,
  output logic               busy
);

  seqCtl_t  ctl;
  seqStat_t stat;

  drseqControl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .driveReady(driveReady),
    .syncFound(syncFound), .wordValid(wordValid), .crcStrobe(crcStrobe),
    .crcMatch(crcMatch), .stat(stat), .ctl(ctl), .busy(busy)
  );

  drseqDatapath #(
    .DATA_W(DATA_W), .WORDS_PER_SECTOR(WORDS_PER_SECTOR), .SEC_W(SEC_W),
    .DRIVE_W(DRIVE_W), .PASSWORD(PASSWORD)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .stat(stat), .cmdPtr(cmdPtr),
    .cmdDrive(cmdDrive), .driveSel(driveSel), .statusRead(statusRead),
    .faultIn(faultIn), .seekDoneIn(seekDoneIn), .indexPulse(indexPulse),
    .sectorPulse(sectorPulse), .sectorNum(sectorNum), .wordValid(wordValid),
    .wordData(wordData), .dmaReq(dmaReq), .dmaWrite(dmaWrite),
    .dmaAddr(dmaAddr), .dmaWData(dmaWData), .dmaAck(dmaAck),
    .dmaRData(dmaRData), .status(status), .irq(irq)
  );

endmodule

// File: rtl/drseqChecker.sv
module drseqChecker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              dmaReq,
  input logic              dmaWrite,
  input logic              dmaAck,
  input logic [DATA_W-1:0] dmaAddr,
  input logic [7:0]        status,
  input logic              irq,
  input logic              busy,
  input logic              statusRead,
  input logic              faultIn,
  input logic              seekDoneIn
);

  // R1: no DMA traffic while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !dmaReq);

  // R3: a program error never coexists with a memory write
  a_r3_no_write_after_prog: assert property (@(posedge clk) disable iff (!rstN)
    (dmaReq && dmaWrite) |-> !status[4]);

  // R6: consecutive data writes step the address by one
  a_r6_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    (dmaReq && dmaWrite && dmaAck) |=>
      (!(dmaReq && dmaWrite) || dmaAddr == DATA_W'($past(dmaAddr) + 1'b1)));

  // R8: each command ends with exactly one outcome flag
  a_r8_single_outcome: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> ($countones(status & 8'hF5) == 1));

  // R10: the interrupt never rises without a flag behind it
  a_r10_irq_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> (status != 8'h00));

  // R11: a status read while idle with no event leaves all flags clear
  a_r11_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && !busy && !faultIn && !seekDoneIn) |=> (status == 8'h00 && !irq));

endmodule

bind diskReadSeq drseqChecker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .dmaReq(dmaReq), .dmaWrite(dmaWrite),
  .dmaAck(dmaAck), .dmaAddr(dmaAddr), .status(status), .irq(irq),
  .busy(busy), .statusRead(statusRead), .faultIn(faultIn),
  .seekDoneIn(seekDoneIn)
);

// File: tb/sim_diskReadSeq.sv
module sim_diskReadSeq;
  localparam int CLK_PERIOD = 10;
  localparam int W = 128;
  localparam logic [15:0] PW = 16'hC35A;
  localparam logic [7:0] B_DONE = 8'h01, B_FAULT = 8'h02, B_NRDY = 8'h04,
    B_SEEK = 8'h08, B_PROG = 8'h10, B_ADDR = 8'h20, B_DATA = 8'h40, B_OVR = 8'h80;

  logic clk = 1'b0, rstN = 1'b0;
  logic cmdStart = 0, statusRead = 0, driveReady = 1, faultIn = 0, seekDoneIn = 0;
  logic indexPulse = 0, sectorPulse = 0, syncFound = 0, wordValid = 0;
  logic crcStrobe = 0, crcMatch = 0, dmaAck = 0;
  logic [15:0] cmdPtr = 0, wordData = 0, dmaRData = 0;
  logic [1:0]  cmdDrive = 0;
  logic [7:0]  sectorNum = 0;
  logic [1:0]  driveSel;
  logic        dmaReq, dmaWrite, irq, busy;
  logic [15:0] dmaAddr, dmaWData;
  logic [7:0]  status;

  diskReadSeq #(.DATA_W(16), .WORDS_PER_SECTOR(W), .SEC_W(8), .DRIVE_W(2),
    .PASSWORD(PW)) u0 (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdPtr(cmdPtr),
    .cmdDrive(cmdDrive), .statusRead(statusRead), .driveSel(driveSel),
    .driveReady(driveReady), .faultIn(faultIn), .seekDoneIn(seekDoneIn),
    .indexPulse(indexPulse), .sectorPulse(sectorPulse), .sectorNum(sectorNum),
    .syncFound(syncFound), .wordValid(wordValid), .wordData(wordData),
    .crcStrobe(crcStrobe), .crcMatch(crcMatch), .dmaReq(dmaReq),
    .dmaWrite(dmaWrite), .dmaAddr(dmaAddr), .dmaWData(dmaWData),
    .dmaAck(dmaAck), .dmaRData(dmaRData), .status(status), .irq(irq), .busy(busy));

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [15:0] mem [0:4095];
  logic [15:0] expMem [0:4095];
  logic [15:0] rdAddr [0:7];
  int reads = 0, writes = 0, lat = 0;
  bit stall = 0;
  int checks = 0, failures = 0;

  // host memory behind the DMA port with random latency
  initial begin
    forever begin
      @(negedge clk);
      if (dmaAck) dmaAck = 1'b0;
      else if (dmaReq && !stall) begin
        if (lat > 0) lat = lat - 1;
        else begin
          dmaAck = 1'b1;
          if (dmaWrite) begin
            mem[dmaAddr[11:0]] = dmaWData;
            writes = writes + 1;
          end else begin
            dmaRData = mem[dmaAddr[11:0]];
            if (reads < 8) rdAddr[reads] = dmaAddr;
            reads = reads + 1;
          end
          lat = int'($urandom % 3);
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int sectorsFor(input logic [15:0] len);
    return (len == 16'd0) ? 1 : int'(len);
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setupParams(input logic [15:0] ptr, hdr, start, len, pw);
    mem[ptr[11:0]] = hdr;
    mem[ptr[11:0] + 12'd1] = start;
    mem[ptr[11:0] + 12'd2] = len;
    mem[ptr[11:0] + 12'd3] = pw;
  endtask

  task automatic issue(input logic [15:0] ptr);
    reads = 0; writes = 0;
    @(negedge clk); cmdPtr = ptr; cmdDrive = ptr[1:0]; cmdStart = 1'b1;
    @(negedge clk); cmdStart = 1'b0;
  endtask

  task automatic waitFetch();
    while (reads < 4 && busy) @(negedge clk);
    tick(3);
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
    tick(1);
  endtask

  task automatic sectorPulseOf(input logic [7:0] n);
    @(negedge clk); sectorNum = n; sectorPulse = 1'b1;
    @(negedge clk); sectorPulse = 1'b0;
  endtask

  task automatic sendSector(input logic [7:0] secNo, input logic [15:0] hdrWord,
                            input bit crcGood, input logic [15:0] firstAddr, input int gap);
    sectorPulseOf(secNo);
    tick(2);
    syncFound = 1'b1; @(negedge clk); syncFound = 1'b0;
    wordValid = 1'b1; wordData = hdrWord; @(negedge clk); wordValid = 1'b0;
    tick(2);
    for (int i = 0; i < W; i++) begin
      logic [15:0] d;
      d = 16'($urandom);
      expMem[firstAddr[11:0] + 12'(i)] = d;
      wordValid = 1'b1; wordData = d; @(negedge clk); wordValid = 1'b0;
      tick(gap - 1);
    end
    crcStrobe = 1'b1; crcMatch = crcGood; @(negedge clk);
    crcStrobe = 1'b0; crcMatch = 1'b0;
    tick(3);
  endtask

  task automatic checkMem(input logic [15:0] first, input int n, input string req);
    int bad = 0;
    int firstBad = -1;
    for (int i = 0; i < n; i++)
      if (mem[first[11:0] + 12'(i)] !== expMem[first[11:0] + 12'(i)]) begin
        bad++;
        if (firstBad < 0) firstBad = i;
      end
    check(bad == 0, req, "memory words wrong", bad, 0);
  endtask

  task automatic goodRead(input logic [15:0] len, input bit extraStart);
    logic [15:0] ptr, start, hdr;
    logic [7:0] trk, sec;
    int nsec;
    ptr = 16'($urandom % 60) + 16'd4;
    start = 16'h0400 + 16'($urandom % 1024);
    trk = 8'($urandom); sec = 8'($urandom % 200);
    hdr = {trk, sec};
    nsec = sectorsFor(len);
    setupParams(ptr, hdr, start, len, PW);
    issue(ptr);
    waitFetch();
    check(rdAddr[0] == ptr && rdAddr[1] == ptr + 1 && rdAddr[2] == ptr + 2 &&
          rdAddr[3] == ptr + 3, "R2", "fetch address order", rdAddr[3], ptr + 3);
    if (extraStart) begin
      @(negedge clk); cmdPtr = ptr + 16'd100; cmdStart = 1'b1;
      @(negedge clk); cmdStart = 1'b0;
    end
    sectorPulseOf(sec + 8'd50);   // wrong sector, ignored (R4)
    tick(2);
    check(busy == 1'b1 && status == 8'h00, "R4", "wrong sector changed state",
          {busy, status}, 9'h100);
    for (int k = 0; k < nsec; k++)
      sendSector(sec + 8'(k), {trk, sec + 8'(k)}, 1'b1, start + 16'(k * W),
                 4 + int'($urandom % 2));
    waitIdle();
    check(status == B_DONE, "R8", "done status", status, B_DONE);
    check(irq == 1'b1, "R10", "irq after done", irq, 1);
    check(writes == nsec * W, "R6", "write count", writes, nsec * W);
    checkMem(start, nsec * W, "R6");
    if (extraStart) check(reads == 4, "R13", "busy start refetched", reads, 4);
    @(negedge clk); statusRead = 1'b1; @(negedge clk); statusRead = 1'b0;
    check(status == 8'h00 && irq == 1'b0, "R11", "status read clear",
          {irq, status}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) begin mem[i] = 16'h0; expMem[i] = 16'h0; end
    void'($urandom(32'h5EED1234));
    tick(3);
    rstN = 1'b1;
    tick(1);
    check(status == 8'h00 && irq == 0 && busy == 0 && dmaReq == 0, "R1",
          "reset state", {dmaReq, busy, irq, status}, 0);

    // R12: event flags
    @(negedge clk); faultIn = 1'b1; @(negedge clk); faultIn = 1'b0;
    check(status == B_FAULT && irq == 1'b0, "R12", "fault flag", {irq, status}, B_FAULT);
    @(negedge clk); seekDoneIn = 1'b1; @(negedge clk); seekDoneIn = 1'b0;
    check(status == (B_FAULT | B_SEEK) && irq == 1'b1, "R12", "seek flag",
          {irq, status}, {1'b1, B_FAULT | B_SEEK});

    // R1 not ready; R11 start clears older flags
    driveReady = 1'b0;
    setupParams(16'h0010, 16'h0105, 16'h0800, 16'd1, PW);
    issue(16'h0010);
    waitIdle();
    check(status == B_NRDY, "R1", "not ready status", status, B_NRDY);
    check(reads == 0 && writes == 0, "R1", "DMA on not ready", reads + writes, 0);
    check(irq == 1'b1, "R10", "irq after abort", irq, 1);
    driveReady = 1'b1;

    // R3 bad password
    setupParams(16'h0020, 16'h0207, 16'h0800, 16'd1, PW ^ 16'h0001);
    issue(16'h0020);
    waitIdle();
    check(status == B_PROG, "R3", "password status", status, B_PROG);
    check(reads == 4 && writes == 0, "R3", "DMA count", reads * 100 + writes, 400);

    // R4 index timeout
    setupParams(16'h0030, 16'h0309, 16'h0800, 16'd1, PW);
    issue(16'h0030);
    waitFetch();
    sectorPulseOf(8'h0A);
    @(negedge clk); indexPulse = 1'b1; @(negedge clk); indexPulse = 1'b0;
    tick(1);
    check(busy == 1'b1, "R4", "first index aborted", busy, 1);
    @(negedge clk); indexPulse = 1'b1; @(negedge clk); indexPulse = 1'b0;
    tick(1);
    check(busy == 1'b0 && status == B_ADDR, "R4", "timeout status", status, B_ADDR);

    // R5 header mismatch
    setupParams(16'h0040, 16'h040B, 16'h0900, 16'd1, PW);
    issue(16'h0040);
    waitFetch();
    sendSector(8'h0B, 16'h050B, 1'b1, 16'h0F00, 4);
    waitIdle();
    check(status == B_ADDR && writes == 0, "R5", "header mismatch",
          {writes[7:0], status}, B_ADDR);

    // R7 CRC failure
    setupParams(16'h0050, 16'h060C, 16'h0A00, 16'd2, PW);
    issue(16'h0050);
    waitFetch();
    sendSector(8'h0C, 16'h060C, 1'b0, 16'h0A00, 4);
    waitIdle();
    check(status == B_DATA, "R7", "crc status", status, B_DATA);
    check(writes == W, "R7", "writes before crc abort", writes, W);

    // R9 overrun with stalled DMA
    stall = 1'b1;
    setupParams(16'h0060, 16'h070D, 16'h0B00, 16'd1, PW);
    reads = 0; writes = 0;
    stall = 1'b0;
    issue(16'h0060);
    waitFetch();
    stall = 1'b1;
    sendSector(8'h0D, 16'h070D, 1'b1, 16'h0F00, 2);
    waitIdle();
    check(status == B_OVR, "R9", "overrun status", status, B_OVR);
    check(dmaReq == 1'b0 && writes == 0, "R9", "pending dropped",
          {dmaReq, writes[7:0]}, 0);
    stall = 1'b0;

    // good reads: directed counts 0, 2 and random ones (R6, R8, R13)
    goodRead(16'd0, 1'b0);
    goodRead(16'd2, 1'b1);
    for (int t = 0; t < 3; t++) goodRead(16'($urandom % 3), t == 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule